// File: doc/BRIEF.md
# Acquisition Control Register with Qualified Configuration Writes

This block is a host-writable control register for a data-acquisition controller. A synchronous byte write port with an address decode reaches two locations: a control/strobe register and a mode register. In enhanced mode, a write to the control register can fire self-timed clear strobes toward three sticky flags: interrupt, external trigger and external interrupt. Each strobe stays high for a fixed number of system clocks, about 1.5 µs nominal, and then drops by itself.

The three upper configuration bits are guarded by two levels. The first level is a qualifier bit, which can change only while the mode register holds enhanced mode. The second level is that bits 5 to 7 accept new data only while the qualifier is already set. The upper bits are a sample-arming enable, a post-trigger strobe select and a pacer time-base select. The host changes them in three separate writes: set the qualifier, write the new bits with the qualifier still set, then clear the qualifier.

Top module: `acq_ctl_csr`

## Requirements
- R1: After reset, all three clear strobes are low, `armed_o`, `post_sel_o` and `pacer_fast_o` are 0, the qualifier is 0 and the mode register selects standard mode.
- R2: In enhanced mode, a control-register write fires a strobe for each data bit set at positions 0, 1 and 2, whatever the qualifier holds. Bit 0 drives `clr_irq_o`, bit 1 drives `clr_trig_o` and bit 2 drives `clr_xirq_o`. The strobe is high from the cycle after the write. A 0 in those positions fires nothing.
- R3: A strobe stays high for exactly PULSE_CYC clocks and then returns to 0 with no further write. PULSE_CYC is computed as CLK_HZ/1000 × PULSE_NS / 1,000,000, with a minimum of 1.
- R4: A new firing write to a strobe that is already high restarts its full PULSE_CYC width, counted from that write.
- R5: The qualifier (control bit 4) takes the written value only on control-register writes made while enhanced mode is on. In standard mode it keeps its value.
- R6: Control-register bits 7..5 take the written data only when the qualifier was already 1 before that write. The new values appear in the cycle after the write. Otherwise the bits hold their values.
- R7: Bit 7 appears on `pacer_fast_o`, where 1 selects the 10 MHz time base and 0 selects 1 MHz. Bit 6 appears on `post_sel_o` and bit 5 on `armed_o`.
- R8: A write to the mode register sets enhanced mode from data bit 4. The new mode applies from the next write onward.
- R9: A write to any other address, or a cycle with `wr_en` low, changes no state and fires no strobe.
- R10: In standard mode, control-register writes fire no strobes, whatever the data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data byte |
| clr_irq_o | output | 1 | Clear strobe for the interrupt flag |
| clr_trig_o | output | 1 | Clear strobe for the external-trigger flag |
| clr_xirq_o | output | 1 | Clear strobe for the external-interrupt flag |
| armed_o | output | 1 | Post-trigger sample-count arming enable |
| post_sel_o | output | 1 | Post-trigger counter start strobe select |
| pacer_fast_o | output | 1 | Pacer time base: 1 = 10 MHz, 0 = 1 MHz |

## Verification
The bench builds the block with CLK_HZ = 20,000,000 and the default PULSE_NS of 1500, which gives a strobe width of 30 clocks. This short width lets many strobes expire during the random phase, and it keeps the restart test and an exact width count cheap. The default address map is kept, and one address outside it is used to cover the ignored-write case. The random writes mix both modes and both qualifier states, so the stuck-qualifier case after leaving enhanced mode is reached as well.

// File: rtl/acq_csr_pkg.sv
package acq_csr_pkg;

    localparam int NUM_CLR   = 3;
    localparam int QUAL_BIT  = 4;
    localparam int ENH_BIT   = 4;
    localparam int UPPER_LSB = 5;
    localparam int UPPER_W   = 3;

    typedef enum logic [1:0] {
        CLR_IRQ  = 2'd0,
        CLR_TRIG = 2'd1,
        CLR_XIRQ = 2'd2
    } clr_idx_t;

    typedef enum logic [1:0] {
        HIT_NONE = 2'd0,
        HIT_CSR  = 2'd1,
        HIT_MODE = 2'd2
    } hit_t;

    // Field order follows bit order 7..5 of the control register.
    typedef struct packed {
        logic pacer_fast;
        logic post_sel;
        logic armed;
    } upper_cfg_t;

    function automatic int pulse_cycles(longint unsigned clk_hz, longint unsigned width_ns);
        longint unsigned c;
        c = (clk_hz / 64'd1000) * width_ns / 64'd1000000;
        if (c < 64'd1) return 1;
        return int'(c);
    endfunction

    function automatic upper_cfg_t upper_from_byte(logic [7:0] d);
        upper_cfg_t u;
        u = upper_cfg_t'(d[UPPER_LSB +: UPPER_W]);
        return u;
    endfunction

endpackage

// File: rtl/csr_bus_decode.sv
module csr_bus_decode
    import acq_csr_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter logic [ADDR_W-1:0] CSR_ADDR  = 'h2,
    parameter logic [ADDR_W-1:0] MODE_ADDR = 'h3
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output hit_t              hit
);
    always_comb begin
        hit = HIT_NONE;
        if (wr_en) begin
            if (wr_addr == CSR_ADDR)       hit = HIT_CSR;
            else if (wr_addr == MODE_ADDR) hit = HIT_MODE;
        end
    end
endmodule

// File: rtl/csr_qual_ctrl.sv
module csr_qual_ctrl
    import acq_csr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               csr_wr,
    input  logic               mode_wr,
    input  logic [7:0]         wr_data,
    output logic               enh_mode,
    output logic               qual,
    output upper_cfg_t         cfg,
    output logic [NUM_CLR-1:0] clr_fire
);
    logic       unused_bits;
    upper_cfg_t cfg_next;
    logic       qual_next;
    logic       enh_next;

    assign unused_bits = wr_data[3];

    always_comb begin
        enh_next  = enh_mode;
        qual_next = qual;
        cfg_next  = cfg;
        if (mode_wr) enh_next = wr_data[ENH_BIT];
        if (csr_wr && enh_mode) qual_next = wr_data[QUAL_BIT];
        // The gate uses the qualifier held before this write.
        if (csr_wr && qual) cfg_next = upper_from_byte(wr_data);
    end

    always_comb begin
        clr_fire = '0;
        if (csr_wr && enh_mode) clr_fire = wr_data[NUM_CLR-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            enh_mode <= 1'b0;
            qual     <= 1'b0;
            cfg      <= '0;
        end else begin
            enh_mode <= enh_next;
            qual     <= qual_next;
            cfg      <= cfg_next;
        end
    end
endmodule

// File: rtl/csr_pulse_timer.sv
module csr_pulse_timer #(
    parameter int CYC = 30
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    output logic pulse
);
    localparam int CW = $clog2(CYC + 1);

    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)                 remain <= '0;
        else if (fire)           remain <= CW'(CYC);
        else if (remain != '0)   remain <= remain - 1'b1;
    end

    assign pulse = (remain != '0);
endmodule

// File: rtl/acq_ctl_csr.sv
module acq_ctl_csr
    import acq_csr_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter logic [ADDR_W-1:0] CSR_ADDR  = 'h2,
    parameter logic [ADDR_W-1:0] MODE_ADDR = 'h3,
    parameter longint CLK_HZ   = 125000000,
    parameter longint PULSE_NS = 1500
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic              clr_irq_o,
    output logic              clr_trig_o,
    output logic              clr_xirq_o,
    output logic              armed_o,
    output logic              post_sel_o,
    output logic              pacer_fast_o
);
    localparam int PULSE_CYC = pulse_cycles(CLK_HZ, PULSE_NS);

    hit_t               hit;
    logic               csr_wr;
    logic               mode_wr;
    logic               enh_mode;
    logic               qual;
    upper_cfg_t         cfg;
    logic [NUM_CLR-1:0] clr_fire;
    logic [NUM_CLR-1:0] clr_vec;

    csr_bus_decode #(
        .ADDR_W(ADDR_W), .CSR_ADDR(CSR_ADDR), .MODE_ADDR(MODE_ADDR)
    ) u_dec (
        .wr_en(wr_en), .wr_addr(wr_addr), .hit(hit)
    );

    assign csr_wr  = (hit == HIT_CSR);
    assign mode_wr = (hit == HIT_MODE);

    csr_qual_ctrl u_ctrl (
        .clk(clk), .rst(rst), .csr_wr(csr_wr), .mode_wr(mode_wr),
        .wr_data(wr_data), .enh_mode(enh_mode), .qual(qual),
        .cfg(cfg), .clr_fire(clr_fire)
    );

    for (genvar k = 0; k < NUM_CLR; k++) begin : g_clr
        csr_pulse_timer #(.CYC(PULSE_CYC)) u_tmr (
            .clk(clk), .rst(rst), .fire(clr_fire[k]), .pulse(clr_vec[k])
        );
    end

    assign clr_irq_o    = clr_vec[CLR_IRQ];
    assign clr_trig_o   = clr_vec[CLR_TRIG];
    assign clr_xirq_o   = clr_vec[CLR_XIRQ];
    assign armed_o      = cfg.armed;
    assign post_sel_o   = cfg.post_sel;
    assign pacer_fast_o = cfg.pacer_fast;
endmodule

// File: rtl/acq_ctl_csr_chk.sv
module acq_ctl_csr_chk
    import acq_csr_pkg::*;
#(
    parameter longint CLK_HZ   = 125000000,
    parameter longint PULSE_NS = 1500
) (
    input logic               clk,
    input logic               rst,
    input logic               wr_en,
    input logic               csr_wr,
    input logic               mode_wr,
    input logic               enh_mode,
    input logic               qual,
    input logic [7:0]         wr_data,
    input logic [NUM_CLR-1:0] clr_vec,
    input logic [2:0]         cfg_bits
);
    localparam int PULSE_CYC = pulse_cycles(CLK_HZ, PULSE_NS);

    logic [NUM_CLR-1:0] fire_now;
    assign fire_now = (csr_wr && enh_mode) ? wr_data[NUM_CLR-1:0] : '0;

    assert_upper_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !(csr_wr && qual) |=> $stable(cfg_bits));

    assert_qual_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !(csr_wr && enh_mode) |=> $stable(qual));

    assert_mode_load_R8: assert property (@(posedge clk) disable iff (rst)
        mode_wr |=> (enh_mode == $past(wr_data[ENH_BIT])));

    assert_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(qual) && $stable(enh_mode) && $stable(cfg_bits)));

    for (genvar k = 0; k < NUM_CLR; k++) begin : g_chk
        int run;

        always_ff @(posedge clk) begin
            if (rst)               run <= 0;
            else if (fire_now[k])  run <= 1;
            else if (clr_vec[k])   run <= run + 1;
            else                   run <= 0;
        end

        assert_fire_R2: assert property (@(posedge clk) disable iff (rst)
            fire_now[k] |=> clr_vec[k]);

        assert_no_spurious_R10: assert property (@(posedge clk) disable iff (rst)
            $rose(clr_vec[k]) |-> $past(csr_wr && enh_mode && wr_data[k]));

        assert_width_R3: assert property (@(posedge clk) disable iff (rst)
            clr_vec[k] |-> (run >= 1 && run <= PULSE_CYC));

        assert_restart_R4: assert property (@(posedge clk) disable iff (rst)
            (clr_vec[k] && run < PULSE_CYC) |=> clr_vec[k]);
    end
endmodule

bind acq_ctl_csr acq_ctl_csr_chk #(.CLK_HZ(CLK_HZ), .PULSE_NS(PULSE_NS)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .csr_wr(csr_wr), .mode_wr(mode_wr),
    .enh_mode(enh_mode), .qual(qual), .wr_data(wr_data), .clr_vec(clr_vec),
    .cfg_bits({pacer_fast_o, post_sel_o, armed_o})
);

// File: tb/tb_acq_ctl_csr.sv
module tb_acq_ctl_csr;
    localparam int         ADDR_W = 4;
    localparam logic [3:0] A_CSR  = 4'h2;
    localparam logic [3:0] A_MODE = 4'h3;
    localparam logic [3:0] A_OTH  = 4'h5;
    localparam int         N      = 30;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic clr_irq_o, clr_trig_o, clr_xirq_o, armed_o, post_sel_o, pacer_fast_o;

    always #4 clk = ~clk;

    acq_ctl_csr #(
        .ADDR_W(ADDR_W), .CSR_ADDR(A_CSR), .MODE_ADDR(A_MODE),
        .CLK_HZ(20000000), .PULSE_NS(1500)
    ) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .clr_irq_o(clr_irq_o), .clr_trig_o(clr_trig_o), .clr_xirq_o(clr_xirq_o),
        .armed_o(armed_o), .post_sel_o(post_sel_o), .pacer_fast_o(pacer_fast_o)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // Reference model built from the requirements
    bit m_enh, m_qual;
    bit [2:0] m_up;
    int m_cnt [3];

    always @(posedge clk) begin
        if (rst) begin
            m_enh = 0; m_qual = 0; m_up = 0;
            for (int k = 0; k < 3; k++) m_cnt[k] = 0;
        end else begin
            bit old_q;
            old_q = m_qual;
            for (int k = 0; k < 3; k++) if (m_cnt[k] > 0) m_cnt[k]--;
            if (wr_en && wr_addr == A_CSR) begin
                if (m_enh) begin
                    for (int k = 0; k < 3; k++) if (wr_data[k]) m_cnt[k] = N;
                    m_qual = wr_data[4];
                end
                if (old_q) m_up = wr_data[7:5];
            end
            if (wr_en && wr_addr == A_MODE) m_enh = wr_data[4];
        end
    end

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [5:0] outs();
        return {pacer_fast_o, post_sel_o, armed_o, clr_xirq_o, clr_trig_o, clr_irq_o};
    endfunction

    function automatic logic [5:0] model_outs();
        return {m_up, m_cnt[2] != 0, m_cnt[1] != 0, m_cnt[0] != 0};
    endfunction

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic high_len(input int idx, output int len);
        len = 0;
        while (outs()[idx] && len < 200) begin
            len++;
            @(negedge clk);
        end
    endtask

    // Cycle-by-cycle comparison against the model (R2, R3, R6, R7)
    always @(negedge clk) begin
        if (!rst && !done) check(32'(outs()), 32'(model_outs()), "R2/R3/R6/R7 model compare");
    end

    initial begin
        int len;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check(32'(outs()), 32'h0, "R1 outputs during reset");
        rst = 1'b0;
        @(negedge clk);
        check(32'(outs()), 32'h0, "R1 outputs after reset");

        // Standard mode: no strobes, qualifier stays 0
        wr(A_CSR, 8'hF7);
        check(32'(outs()), 32'h0, "R10 standard mode no strobe");
        wr(A_MODE, 8'h10);
        wr(A_CSR, 8'hE0);
        check(32'(outs()), 32'h0, "R5 qualifier ignored in standard mode");

        // Strobe fire and width
        wr(A_CSR, 8'h01);
        check(32'(outs()), 32'h01, "R2 irq strobe only");
        high_len(0, len);
        check(32'(len), 32'(N), "R3 strobe width");

        // Qualified configuration sequence
        wr(A_CSR, 8'h10);
        check(32'(outs()), 32'h0, "R6 qualifier set, upper unchanged");
        wr(A_CSR, 8'h90);
        check(32'(pacer_fast_o), 1, "R7 pacer 10 MHz select");
        wr(A_CSR, 8'h70);
        check(32'(outs()), 32'h18, "R7 armed and post_sel set, pacer 1 MHz");
        wr(A_CSR, 8'h60);
        check(32'(outs()), 32'h18, "R6 qualifier cleared, bits kept");
        wr(A_CSR, 8'h80);
        check(32'(outs()), 32'h18, "R6 upper held with qualifier 0");

        // Restart
        wr(A_CSR, 8'h02);
        repeat (9) @(negedge clk);
        wr(A_CSR, 8'h02);
        high_len(1, len);
        check(32'(len), 32'(N), "R4 restart full width");

        // Ignored writes
        wr(A_OTH, 8'hFF);
        check(32'(outs()), 32'h18, "R9 other address ignored");
        @(negedge clk);
        wr_addr = A_CSR; wr_data = 8'hFF;
        @(negedge clk);
        check(32'(outs()), 32'h18, "R9 wr_en low ignored");

        // Qualifier stuck at 1 after leaving enhanced mode
        wr(A_CSR, 8'h10);
        wr(A_MODE, 8'h00);
        check(32'(outs()), 32'h18, "R8 mode cleared, no change");
        wr(A_CSR, 8'h07);
        check(32'(outs()), 32'h0, "R5/R10 qualifier kept, no strobe");
        wr(A_CSR, 8'hA0);
        check(32'(outs()), 32'h28, "R5 qualifier still gates upper bits");

        // Random phase
        for (int i = 0; i < 600; i++) begin
            int sel;
            sel = int'($urandom % 6);
            if (sel < 3)       wr(A_CSR, 8'($urandom));
            else if (sel == 3) wr(A_MODE, 8'($urandom));
            else if (sel == 4) wr(A_OTH, 8'($urandom));
            else repeat (int'($urandom % 40)) @(negedge clk);
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule